// File: doc/BRIEF.md
# Three-Channel Programmable Down-Counter Timer

This block holds three 16-bit down-counters that software reaches through a small byte-wide I/O port map. One command port picks a channel and sets how its count is loaded (low byte only, high byte only, or low then high), which operating mode it runs in, and whether it counts in binary or in four-digit decimal. The command port can also freeze a snapshot of a channel's count so that software can read it back. Each channel has its own data port. Writes to that port load the reload count, and reads from it return the live count or the frozen snapshot.

Counting advances on a one-cycle tick-enable pulse and only while the channel's gate is high. Channels 0 and 1 take their gates from pins. The gate of channel 2 is a bit of a separate control port. That port also holds a speaker enable and returns channel 2's output, so software can load a delay count into channel 2 and poll one bit until the delay has run out. In the terminal-count mode a channel's output is low from the command until the count reaches zero, then goes high and stays high. The other mode codes are decoded but not modelled: after the command their output is held high.

Top module: `pit_core`

## Requirements
- R1: After reset, out0, out1, out2 and spk_out are 0, and a read of the control port (0x61) returns 0x00.
- R2: A write to the control port stores bit 0 as channel 2's gate and bit 1 as the speaker enable. A read returns those two bits in place, channel 2's output in bit 5, and 0 in every other bit.
- R3: A write to 0x43 is a command word. Bits 7:6 pick the channel, bits 5:4 the access mode, bits 3:1 the operating mode and bit 0 the counting base. A command affects only the selected channel, and a channel field of 3 affects no channel.
- R4: With access mode 3, the first data-port write after a command is the low byte and the second is the high byte. Counting begins only once the high byte has been written.
- R5: In operating mode 0, a channel's output stays 0 while a count of N is running and becomes 1 after exactly N gated ticks. It then stays 1.
- R6: While a channel's gate is low its count and output do not change, whatever the ticks do.
- R7: A command with access mode 0 freezes the selected channel's count. The following data-port reads return the frozen low byte and then the frozen high byte (access mode 3), after which reads return the live count again.
- R8: A new command to a channel stops its counting, forces a mode-0 output low and resets the byte order, so the next data write is taken as the low byte.
- R9: With bit 0 of the command set, the count steps down as four decimal digits, so a count loaded as 0x0010 reaches zero after 10 ticks.
- R10: With access mode 1, a single data write loads the low byte and clears the high byte. With access mode 2, it loads the high byte and clears the low byte. Reads in those modes return only the matching byte.
- R11: Any operating mode other than 0, including codes 6 and 7 (which stand for 2 and 3), sets the channel's output to 1 from the command onward.
- R12: spk_out is 1 only when the speaker enable bit is set and channel 2's output is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle count pulse at the timer tick rate |
| io_addr | input | 8 | I/O port address |
| io_wr | input | 1 | Write strobe, one cycle |
| io_rd | input | 1 | Read strobe, one cycle (advances the read byte order) |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for io_addr, combinational |
| gate0_in | input | 1 | Gate of channel 0 |
| gate1_in | input | 1 | Gate of channel 1 |
| out0 | output | 1 | Channel 0 output |
| out1 | output | 1 | Channel 1 output |
| out2 | output | 1 | Channel 2 output |
| spk_out | output | 1 | Channel 2 output gated by the speaker enable |

## Verification
Channel 2 runs mode-0 delays of several lengths, and each time the polled bit is checked one tick before and on the tick the delay ends. A miscount of one in either direction shows up there. The same decimal-looking count is loaded in binary and in decimal, so the two bases are told apart by when the output rises. Holding the gate low, writing only the first byte, and sending a command to another channel each show whether the counter is started or stopped by the wrong event. Snapshot reads taken after the counter has moved on show whether the frozen value and the live value are being mixed.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int DIGITS = CNT_W / 4;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_WORD  = 2'd3
  } access_e;

  typedef enum logic [2:0] {
    OP_TERM    = 3'd0,
    OP_ONESHOT = 3'd1,
    OP_RATE    = 3'd2,
    OP_SQUARE  = 3'd3,
    OP_SWSTB   = 3'd4,
    OP_HWSTB   = 3'd5
  } op_e;

  typedef struct packed {
    logic [1:0] sel;
    access_e    acc;
    logic [2:0] op;
    logic       bcd;
  } cmd_t;

  // Mode codes 6 and 7 fold onto 2 and 3.
  function automatic logic [2:0] norm_op(input logic [2:0] code);
    if (code[2:1] == 2'b11) return {1'b0, code[1:0]};
    return code;
  endfunction

  // One step down in binary or in packed decimal digits (0 wraps to all nines).
  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v, input logic dec);
    logic [CNT_W-1:0] r;
    logic borrow;
    r = v;
    if (!dec) return v - 1'b1;
    borrow = 1'b1;
    for (int d = 0; d < DIGITS; d++) begin
      if (borrow) begin
        if (r[d*4 +: 4] == 4'd0) r[d*4 +: 4] = 4'd9;
        else begin
          r[d*4 +: 4] = r[d*4 +: 4] - 4'd1;
          borrow = 1'b0;
        end
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/pit_readout.sv
module pit_readout
  import pit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_cmd,
  input  logic              latch_cmd,
  input  access_e           acc,
  input  logic [CNT_W-1:0]  count,
  input  logic              data_rd,
  output logic [BYTE_W-1:0] rbyte
);
  logic             latched;
  logic [CNT_W-1:0] snap;
  logic             rd_hi;
  logic [CNT_W-1:0] src;
  logic             pick_hi;

  assign src     = latched ? snap : count;
  assign pick_hi = (acc == ACC_HI) || ((acc == ACC_WORD) && rd_hi);
  assign rbyte   = pick_hi ? src[CNT_W-1 -: BYTE_W] : src[BYTE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latched <= 1'b0;
      snap    <= '0;
      rd_hi   <= 1'b0;
    end else if (mode_cmd) begin
      latched <= 1'b0;
      rd_hi   <= 1'b0;
    end else if (latch_cmd) begin
      if (!latched) begin
        latched <= 1'b1;
        snap    <= count;
        rd_hi   <= 1'b0;
      end
    end else if (data_rd) begin
      if (acc == ACC_WORD && !rd_hi) begin
        rd_hi <= 1'b1;
      end else begin
        rd_hi   <= 1'b0;
        latched <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              gate,
  input  logic              mode_cmd,
  input  logic              latch_cmd,
  input  access_e           cmd_acc,
  input  logic [2:0]        cmd_op,
  input  logic              cmd_bcd,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              out_q
);
  access_e           acc;
  logic [2:0]        op;
  logic              bcd;
  logic [CNT_W-1:0]  count;
  logic [BYTE_W-1:0] lo_buf;
  logic              wr_hi;
  logic              running;
  logic              step;
  logic [CNT_W-1:0]  next_count;
  logic              hit_tc;
  logic [2:0]        op_new;

  assign op_new     = norm_op(cmd_op);
  assign step       = running && gate && tick_en;
  assign next_count = step_down(count, bcd);
  assign hit_tc     = step && (next_count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= ACC_WORD;
      op      <= 3'd0;
      bcd     <= 1'b0;
      count   <= '0;
      lo_buf  <= '0;
      wr_hi   <= 1'b0;
      running <= 1'b0;
      out_q   <= 1'b0;
    end else if (mode_cmd) begin
      acc     <= cmd_acc;
      op      <= op_new;
      bcd     <= cmd_bcd;
      wr_hi   <= 1'b0;
      running <= 1'b0;
      out_q   <= (op_new != OP_TERM);
    end else if (data_wr) begin
      unique case (acc)
        ACC_LO: begin
          count   <= {{BYTE_W{1'b0}}, wdata};
          running <= 1'b1;
          out_q   <= (op != OP_TERM);
        end
        ACC_HI: begin
          count   <= {wdata, {BYTE_W{1'b0}}};
          running <= 1'b1;
          out_q   <= (op != OP_TERM);
        end
        ACC_WORD: begin
          if (!wr_hi) begin
            lo_buf  <= wdata;
            wr_hi   <= 1'b1;
            running <= 1'b0;
          end else begin
            count   <= {wdata, lo_buf};
            wr_hi   <= 1'b0;
            running <= 1'b1;
            out_q   <= (op != OP_TERM);
          end
        end
        default: ;
      endcase
    end else if (step) begin
      count <= next_count;
      if (hit_tc) out_q <= 1'b1;
    end
  end

  pit_readout u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_cmd  (mode_cmd),
    .latch_cmd (latch_cmd),
    .acc       (acc),
    .count     (count),
    .data_rd   (data_rd),
    .rbyte     (rdata)
  );
endmodule

// File: rtl/pit_ctrl_port.sv
module pit_ctrl_port
  import pit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              spk_ch_out,
  output logic              gate_q,
  output logic              spk_en_q,
  output logic [BYTE_W-1:0] rbyte
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q   <= 1'b0;
      spk_en_q <= 1'b0;
    end else if (wr) begin
      gate_q   <= wdata[0];
      spk_en_q <= wdata[1];
    end
  end

  always_comb begin
    rbyte    = '0;
    rbyte[0] = gate_q;
    rbyte[1] = spk_en_q;
    rbyte[5] = spk_ch_out;
  end
endmodule

// File: rtl/pit_core.sv
module pit_core
  import pit_pkg::*;
#(
  parameter logic [7:0] DATA_BASE = 8'h40,
  parameter logic [7:0] CMD_ADDR  = 8'h43,
  parameter logic [7:0] CTRL_ADDR = 8'h61
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic [7:0] io_addr,
  input  logic       io_wr,
  input  logic       io_rd,
  input  logic [7:0] io_wdata,
  output logic [7:0] io_rdata,
  input  logic       gate0_in,
  input  logic       gate1_in,
  output logic       out0,
  output logic       out1,
  output logic       out2,
  output logic       spk_out
);
  localparam int NUM_CH = 3;
  localparam int SPK_CH = NUM_CH - 1;

  cmd_t              cmd_word;
  logic              cmd_wr;
  logic              ctrl_wr;
  logic              gate2;
  logic              spk_bit;
  logic [7:0]        ctrl_rbyte;
  logic [NUM_CH-1:0] ch_out;
  logic [NUM_CH-1:0] ch_gate;
  logic [7:0]        ch_rbyte [NUM_CH];

  assign cmd_word = cmd_t'(io_wdata);
  assign cmd_wr   = io_wr && (io_addr == CMD_ADDR);
  assign ctrl_wr  = io_wr && (io_addr == CTRL_ADDR);
  assign ch_gate  = {gate2, gate1_in, gate0_in};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [7:0] CH_ADDR = 8'(DATA_BASE + 8'(c));
    logic hit_sel;
    logic mode_cmd;
    logic latch_cmd;
    assign hit_sel   = cmd_wr && (cmd_word.sel == 2'(c));
    assign mode_cmd  = hit_sel && (cmd_word.acc != ACC_LATCH);
    assign latch_cmd = hit_sel && (cmd_word.acc == ACC_LATCH);

    pit_channel u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .gate      (ch_gate[c]),
      .mode_cmd  (mode_cmd),
      .latch_cmd (latch_cmd),
      .cmd_acc   (cmd_word.acc),
      .cmd_op    (cmd_word.op),
      .cmd_bcd   (cmd_word.bcd),
      .data_wr   (io_wr && (io_addr == CH_ADDR)),
      .data_rd   (io_rd && (io_addr == CH_ADDR)),
      .wdata     (io_wdata),
      .rdata     (ch_rbyte[c]),
      .out_q     (ch_out[c])
    );
  end

  pit_ctrl_port u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (ctrl_wr),
    .wdata      (io_wdata),
    .spk_ch_out (ch_out[SPK_CH]),
    .gate_q     (gate2),
    .spk_en_q   (spk_bit),
    .rbyte      (ctrl_rbyte)
  );

  always_comb begin
    io_rdata = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (io_addr == 8'(DATA_BASE + 8'(c))) io_rdata = ch_rbyte[c];
    if (io_addr == CTRL_ADDR) io_rdata = ctrl_rbyte;
  end

  assign out0    = ch_out[0];
  assign out1    = ch_out[1];
  assign out2    = ch_out[SPK_CH];
  assign spk_out = ch_out[SPK_CH] && spk_bit;
endmodule

// File: rtl/pit_checker.sv
module pit_checker #(
  parameter logic [7:0] CMD_ADDR  = 8'h43,
  parameter logic [7:0] CTRL_ADDR = 8'h61
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_en,
  input logic       io_wr,
  input logic [7:0] io_addr,
  input logic [7:0] io_wdata,
  input logic [7:0] io_rdata,
  input logic       out2,
  input logic       gate2,
  input logic       spk_bit,
  input logic       spk_out
);
  // R8: a mode-0 command to channel 2 drives its output low next cycle
  assert_cmd_clears_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == CMD_ADDR && io_wdata[7:6] == 2'd2 &&
     io_wdata[5:4] != 2'd0 && io_wdata[3:1] == 3'd0) |=> !out2);

  // R6: with the gate low and no port write, the output holds
  assert_gate_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate2 && !io_wr) |=> $stable(out2));

  // R5: the output rises only from a tick or from a port write
  assert_rise_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out2) |-> ($past(tick_en) || $past(io_wr)));

  // R2: unused control-port bits read as zero
  assert_ctrl_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr == CTRL_ADDR) |-> (io_rdata[7:6] == 2'd0 && io_rdata[4:2] == 3'd0));

  // R12: the speaker stays silent without its enable
  assert_spk_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !spk_bit |-> !spk_out);
endmodule

bind pit_core pit_checker #(.CMD_ADDR(CMD_ADDR), .CTRL_ADDR(CTRL_ADDR)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_en  (tick_en),
  .io_wr    (io_wr),
  .io_addr  (io_addr),
  .io_wdata (io_wdata),
  .io_rdata (io_rdata),
  .out2     (out2),
  .gate2    (gate2),
  .spk_bit  (spk_bit),
  .spk_out  (spk_out)
);

// File: tb/tb_pit_core.sv
`timescale 1ns/1ps
module tb_pit_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic [7:0] io_addr = 8'h00;
  logic       io_wr = 1'b0;
  logic       io_rd = 1'b0;
  logic [7:0] io_wdata = 8'h00;
  logic [7:0] io_rdata;
  logic       gate0_in = 1'b0;
  logic       gate1_in = 1'b0;
  logic       out0, out1, out2, spk_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pit_core dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .gate0_in(gate0_in), .gate1_in(gate1_in), .out0(out0), .out1(out1),
    .out2(out2), .spk_out(spk_out)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  function automatic logic [7:0] ch2bit();
    return {7'd0, out2};
  endfunction

  task automatic t_reset();
    logic [7:0] d;
    rd(8'h61, d);
    check("R1 ctrl read", d, 8'h00);
    check("R1 outputs", {4'd0, out0, out1, out2, spk_out}, 8'h00);
  endtask

  task automatic t_mode0_delay();
    logic [7:0] d;
    wr(8'h61, 8'h01);
    wr(8'h43, 8'hB0);
    wr(8'h42, 8'h05); wr(8'h42, 8'h00);
    ticks(4);
    rd(8'h61, d);
    check("R5 before terminal", d, 8'h01);
    ticks(1);
    rd(8'h61, d);
    check("R2 R5 at terminal", d, 8'h21);
    ticks(3);
    check("R5 stays high", ch2bit(), 8'h01);
  endtask

  task automatic t_gate_and_latch();
    logic [7:0] d;
    wr(8'h61, 8'h00);
    wr(8'h43, 8'hB0);
    wr(8'h42, 8'h03); wr(8'h42, 8'h00);
    ticks(10);
    check("R6 gate low holds out", ch2bit(), 8'h00);
    wr(8'h43, 8'h80);
    rd(8'h42, d); check("R6 R7 frozen low", d, 8'h03);
    rd(8'h42, d); check("R7 frozen high", d, 8'h00);
    wr(8'h61, 8'h01);
    ticks(2);
    check("R5 not yet", ch2bit(), 8'h00);
    ticks(1);
    check("R5 after gate", ch2bit(), 8'h01);
  endtask

  task automatic t_latch_release();
    logic [7:0] d;
    wr(8'h43, 8'hB0);
    wr(8'h42, 8'h20); wr(8'h42, 8'h00);
    ticks(2);
    wr(8'h43, 8'h80);
    ticks(2);
    rd(8'h42, d); check("R7 snapshot low", d, 8'h1E);
    rd(8'h42, d); check("R7 snapshot high", d, 8'h00);
    rd(8'h42, d); check("R7 live after release", d, 8'h1C);
    rd(8'h42, d);
  endtask

  task automatic t_byte_order();
    logic [7:0] d;
    wr(8'h43, 8'hB0);
    wr(8'h42, 8'h02);
    ticks(5);
    check("R4 no count on low byte only", ch2bit(), 8'h00);
    wr(8'h42, 8'h00);
    ticks(2);
    check("R4 count after high byte", ch2bit(), 8'h01);
    wr(8'h61, 8'h00);
    wr(8'h43, 8'hB0);
    wr(8'h42, 8'h34); wr(8'h42, 8'h12);
    wr(8'h43, 8'h80);
    rd(8'h42, d); check("R4 low byte", d, 8'h34);
    rd(8'h42, d); check("R4 high byte", d, 8'h12);
    wr(8'h61, 8'h01);
  endtask

  task automatic t_recommand();
    wr(8'h43, 8'hB0);
    wr(8'h42, 8'h01); wr(8'h42, 8'h00);
    ticks(1);
    check("R5 count one", ch2bit(), 8'h01);
    wr(8'h43, 8'hB0);
    check("R8 command clears out", ch2bit(), 8'h00);
    wr(8'h42, 8'h07);
    wr(8'h43, 8'hB0);
    wr(8'h42, 8'h03); wr(8'h42, 8'h00);
    ticks(2);
    check("R8 restart low", ch2bit(), 8'h00);
    ticks(1);
    check("R8 byte order reset", ch2bit(), 8'h01);
  endtask

  task automatic t_single_byte();
    logic [7:0] d;
    wr(8'h43, 8'h90);
    wr(8'h42, 8'h04);
    ticks(3);
    check("R10 low-only pending", ch2bit(), 8'h00);
    ticks(1);
    check("R10 low-only done", ch2bit(), 8'h01);
    wr(8'h43, 8'hA0);
    wr(8'h42, 8'h01);
    ticks(5);
    check("R10 high-only running", ch2bit(), 8'h00);
    wr(8'h43, 8'h80);
    rd(8'h42, d); check("R10 high-only read", d, 8'h00);
    rd(8'h42, d); check("R10 high-only live", d, 8'h00);
  endtask

  task automatic t_bcd();
    wr(8'h43, 8'hB0);
    wr(8'h42, 8'h10); wr(8'h42, 8'h00);
    ticks(10);
    check("R9 binary 0x10 not done", ch2bit(), 8'h00);
    wr(8'h43, 8'hB1);
    wr(8'h42, 8'h10); wr(8'h42, 8'h00);
    ticks(9);
    check("R9 decimal pending", ch2bit(), 8'h00);
    ticks(1);
    check("R9 decimal 10 ticks", ch2bit(), 8'h01);
  endtask

  task automatic t_channel0();
    wr(8'h43, 8'h30);
    check("R3 ch2 untouched", ch2bit(), 8'h01);
    check("R3 ch0 low", {7'd0, out0}, 8'h00);
    wr(8'h40, 8'h02); wr(8'h40, 8'h00);
    gate0_in = 1'b0;
    ticks(3);
    check("R6 ch0 gate low", {7'd0, out0}, 8'h00);
    gate0_in = 1'b1;
    ticks(2);
    check("R3 ch0 done", {7'd0, out0}, 8'h01);
    check("R3 ch1 idle", {7'd0, out1}, 8'h00);
    wr(8'h43, 8'hF0);
    check("R3 sel 3 no effect", {6'd0, out0, out2}, 8'h03);
  endtask

  task automatic t_other_modes();
    wr(8'h61, 8'h00);
    wr(8'h43, 8'hB4);
    check("R11 mode 2 out high", ch2bit(), 8'h01);
    wr(8'h43, 8'hB0);
    wr(8'h43, 8'hBC);
    check("R11 code 6 out high", ch2bit(), 8'h01);
    wr(8'h43, 8'hB0);
    wr(8'h43, 8'hB2);
    check("R11 mode 1 out high", ch2bit(), 8'h01);
  endtask

  task automatic t_speaker();
    logic [7:0] d;
    check("R12 disabled", {7'd0, spk_out}, 8'h00);
    wr(8'h61, 8'h02);
    check("R12 enabled", {7'd0, spk_out}, 8'h01);
    rd(8'h61, d);
    check("R2 readback", d, 8'h22);
    wr(8'h43, 8'hB0);
    check("R12 out low", {7'd0, spk_out}, 8'h00);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mode0_delay();
    t_gate_and_latch();
    t_latch_release();
    t_byte_order();
    t_recommand();
    t_single_byte();
    t_bcd();
    t_channel0();
    t_other_modes();
    t_speaker();
    done = 1'b1;
    finish_run();
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end
endmodule